// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a synchronous host read and write an external asynchronous static memory of 262,144 bytes. The memory is selected through two chip enables of opposite polarity: an active-low select and an active-high select. It also has an active-low output enable and an active-low write enable. Each timing limit of the memory is given as a parameter in nanoseconds. The block turns every limit into a whole number of clock cycles, using the clock period parameter. Each figure is rounded up and is never less than one cycle. Reads and writes then run as fixed sequences of cycles built from these counts.

The host holds `reqValid`, together with the direction, address and write data, until `rspReady` pulses for one cycle. On a read, the returned byte appears on `rspData` in the same cycle. On the memory side the block drives the address, the selects, the enables, the outgoing byte and a drive enable for the pad buffers. It samples the incoming byte.

A retention input parks the memory in its deselected low-power state. When that input is released, the block waits one read cycle time before it starts any access. While idle, the memory is always left deselected.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, and whenever idle, the block drives `memCeN`=1, `memCe2`=0, `memOeN`=1, `memWeN`=1, `memDrv`=0 and `rspReady`=0.
- R2: A read is accepted on the first clock edge at which the block is idle and sees `reqValid`=1 with `reqWrite`=0. On that edge the address appears on `memAddr`, `memCeN`=0, `memCe2`=1, `memOeN`=0 and `memWeN`=1. This state holds for RD_C cycles. RD_C is the largest of the rounded-up address access, chip enable access and output enable access counts, which is 3 at the defaults.
- R3: On the RD_C-th edge after acceptance, the block captures `memDin` into `rspData` and raises `rspReady` for exactly one cycle. On the same edge it deselects the memory and sets `memOeN` back to 1.
- R4: A write (`reqWrite`=1) drives `memCeN`=0, `memCe2`=1 and `memWeN`=0 from its accept edge. It keeps `memOeN`=1 for the whole write. WE stays low for PULSE_C cycles. PULSE_C is the largest of the write pulse count, the address-valid count, the chip-enable-to-end count and the sum of the write-to-high-Z and data setup counts, which is 3 at the defaults.
- R5: `memDrv` rises WHZ_C edges after WE falls, which is 1 edge at the defaults, and carries the write byte on `memDout`. WE rises together with the deselect. `memDrv` falls one edge later, and `rspReady` pulses in that cycle.
- R6: A read of an address returns the byte most recently written there.
- R7: Two accesses never start closer than CYC_C cycles apart. CYC_C is the larger of the rounded-up read and write cycle times. With 100 ns cycle times at 20 ns, the second of two back-to-back reads starts 5 cycles after the first. At the defaults a new read starts on the edge after the previous ready, which is RD_C+1 cycles after the previous start.
- R8: While `retainReq`=1 and the block is idle, the memory stays deselected and host requests are not accepted: no select and no `rspReady`. Retention takes priority over a request in the same cycle.
- R9: After `retainReq` falls, the first access selects the memory on the (REC_C+1)-th edge after the edge that sees the release. REC_C is the rounded-up recovery time, one read cycle time by default, giving 3 cycles.
- R10: `memCeN` and `memCe2` are always opposite. `memAddr` does not change while the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Host request, held until `rspReady` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Host word address |
| reqWdata | input | 8 | Host write byte |
| retainReq | input | 1 | Level request to hold the memory in retention |
| rspReady | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Read byte, valid while `rspReady` is high |
| memAddr | output | 18 | Memory address |
| memCeN | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDout | output | 8 | Byte driven toward the memory |
| memDrv | output | 1 | Drive enable for the data pads |
| memDin | input | 8 | Byte sampled from the memory |

## Verification
At the defaults, a read holds its select and enable pattern for 3 cycles after the accept edge. Ready and data arrive on the 3rd edge. A write's drive enable rises 1 edge after acceptance and WE rises on the 3rd edge; ready and drive release come on the 4th. After retention is released, the first select appears on the 4th edge. With 100 ns cycle times, back-to-back starts sit 5 edges apart. Every output is updated by one register stage at an edge, so the bench samples it at the following falling edge. The bench counts those falling edges from the accept edge and compares each cycle with the pattern expected for that count. A behavioural memory model in the bench returns data only after the address access time. A read captured too early therefore shows up as a wrong byte.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef struct packed {
    logic startRd;
    logic startWr;
    logic selOff;
    logic weHigh;
    logic drvOn;
    logic drvOff;
    logic capture;
    logic readyPulse;
  } ctlStrobes_t;

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_ACE_NS = 55,
  parameter int T_OE_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_AW_NS  = 50,
  parameter int T_CW_NS  = 50,
  parameter int T_WP_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_WHZ_NS = 20,
  parameter int T_REC_NS = 55
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        retainReq,
  output ctlStrobes_t strobes
);

  localparam int RC_C  = nsToCycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int WC_C  = nsToCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int AA_C  = nsToCycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int ACE_C = nsToCycles(T_ACE_NS, CLK_PERIOD_NS);
  localparam int OE_C  = nsToCycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int AW_C  = nsToCycles(T_AW_NS, CLK_PERIOD_NS);
  localparam int CW_C  = nsToCycles(T_CW_NS, CLK_PERIOD_NS);
  localparam int WP_C  = nsToCycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int DW_C  = nsToCycles(T_DW_NS, CLK_PERIOD_NS);
  localparam int WHZ_C = nsToCycles(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int REC_C = nsToCycles(T_REC_NS, CLK_PERIOD_NS);

  localparam int RD_C    = maxOf(AA_C, maxOf(ACE_C, OE_C));
  localparam int PULSE_C = maxOf(maxOf(WP_C, AW_C), maxOf(CW_C, WHZ_C + DW_C));
  localparam int CYC_C   = maxOf(RC_C, WC_C);
  localparam int MAX_C   = maxOf(maxOf(RD_C, PULSE_C), maxOf(CYC_C, REC_C));
  localparam int CNT_W   = $clog2(MAX_C + 2);
  localparam int GAP_W   = $clog2(CYC_C + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WPULSE, ST_WREL, ST_RETAIN, ST_RECOVER
  } ctlState_t;

  ctlState_t state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseCntNext;
  logic [GAP_W-1:0] gapCnt, gapCntNext;

  always_comb begin
    stateNext    = state;
    phaseCntNext = phaseCnt + 1'b1;
    gapCntNext   = (gapCnt != '0) ? gapCnt - 1'b1 : gapCnt;
    strobes      = '0;
    case (state)
      ST_IDLE: begin
        phaseCntNext = '0;
        if (retainReq) begin
          stateNext = ST_RETAIN;
        end else if (reqValid && gapCnt == '0) begin
          gapCntNext = GAP_W'(CYC_C - 1);
          if (reqWrite) begin
            strobes.startWr = 1'b1;
            stateNext       = ST_WPULSE;
          end else begin
            strobes.startRd = 1'b1;
            stateNext       = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (phaseCnt == CNT_W'(RD_C - 1)) begin
          strobes.capture    = 1'b1;
          strobes.selOff     = 1'b1;
          strobes.readyPulse = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      ST_WPULSE: begin
        if (phaseCnt == CNT_W'(WHZ_C - 1)) strobes.drvOn = 1'b1;
        if (phaseCnt == CNT_W'(PULSE_C - 1)) begin
          strobes.weHigh = 1'b1;
          strobes.selOff = 1'b1;
          stateNext      = ST_WREL;
        end
      end
      ST_WREL: begin
        strobes.drvOff     = 1'b1;
        strobes.readyPulse = 1'b1;
        stateNext          = ST_IDLE;
      end
      ST_RETAIN: begin
        phaseCntNext = '0;
        if (!retainReq) stateNext = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (phaseCnt == CNT_W'(REC_C - 1)) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      gapCnt   <= '0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseCntNext;
      gapCnt   <= gapCntNext;
    end
  end

endmodule

// File: rtl/sram_ctl_dp.sv
`timescale 1ns/1ps
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDrv,
  output logic [DATA_W-1:0] rspData,
  output logic              rspReady
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDout  <= '0;
      memCeN   <= 1'b1;
      memCe2   <= 1'b0;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDrv   <= 1'b0;
      rspData  <= '0;
      rspReady <= 1'b0;
    end else begin
      rspReady <= strobes.readyPulse;
      if (strobes.startRd || strobes.startWr) begin
        memAddr <= reqAddr;
        memCeN  <= 1'b0;
        memCe2  <= 1'b1;
      end
      if (strobes.startRd) memOeN <= 1'b0;
      if (strobes.startWr) begin
        memWeN  <= 1'b0;
        memDout <= reqWdata;
      end
      if (strobes.selOff) begin
        memCeN <= 1'b1;
        memCe2 <= 1'b0;
        memOeN <= 1'b1;
      end
      if (strobes.weHigh)  memWeN  <= 1'b1;
      if (strobes.drvOn)   memDrv  <= 1'b1;
      if (strobes.drvOff)  memDrv  <= 1'b0;
      if (strobes.capture) rspData <= memDin;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_ACE_NS = 55,
  parameter int T_OE_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_AW_NS  = 50,
  parameter int T_CW_NS  = 50,
  parameter int T_WP_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_WHZ_NS = 20,
  parameter int T_REC_NS = T_RC_NS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              retainReq,
  output logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrv,
  input  logic [DATA_W-1:0] memDin
);

  ctlStrobes_t strobes;

  sram_ctl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_ACE_NS(T_ACE_NS), .T_OE_NS(T_OE_NS),
    .T_WC_NS(T_WC_NS), .T_AW_NS(T_AW_NS), .T_CW_NS(T_CW_NS), .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS), .T_WHZ_NS(T_WHZ_NS), .T_REC_NS(T_REC_NS)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .retainReq(retainReq), .strobes(strobes)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDin(memDin), .memAddr(memAddr), .memDout(memDout),
    .memCeN(memCeN), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDrv(memDrv), .rspData(rspData), .rspReady(rspReady)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
`timescale 1ns/1ps
module sram_async_ctl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              retainReq,
  input logic              rspReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe2,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDrv
);

  // R4: a write strobe never overlaps an enabled memory output
  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !memCeN) |-> memOeN);

  // R5: the controller drives the bus only while the memory output is disabled
  p_drive_oe_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    memDrv |-> memOeN);

  // R5: data is still driven in the cycle WE returns high
  p_drive_at_we_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDrv);

  // R5: drive is released one cycle after WE rises
  p_drive_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |=> !memDrv);

  // R3: ready is a single-cycle pulse
  p_ready_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);

  // R10: the two chip enables always agree on selection
  p_ce_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    memCeN != memCe2);

  // R10: the address holds while the memory remains selected
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

  // R8: a deselected memory stays deselected while retention is requested
  p_retain_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retainReq && memCeN) |=> memCeN);

endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .retainReq(retainReq), .rspReady(rspReady),
  .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2), .memOeN(memOeN),
  .memWeN(memWeN), .memDrv(memDrv)
);

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_mem_model #(
  parameter int HALF_NS = 10,
  parameter int T_AA_NS = 55
) (
  input  logic        clk,
  input  logic [17:0] addr,
  input  logic        ceN,
  input  logic        ce2,
  input  logic        oeN,
  input  logic        weN,
  input  logic        drv,
  input  logic [7:0]  dout,
  output logic [7:0]  din
);
  logic [7:0] store [int];
  bit         wasOn = 0;
  logic [17:0] lastAddr = '0;
  time        startT = 0;

  initial din = 8'hEE;

  always @(posedge clk) begin
    if (!ceN && ce2 && !weN && drv) store[int'(addr)] = dout;
  end

  always @(negedge clk) begin
    if (!ceN && ce2 && !oeN && weN) begin
      if (!wasOn || addr != lastAddr) startT = $time - HALF_NS;
      wasOn = 1;
      lastAddr = addr;
      if ($time + HALF_NS - startT >= T_AA_NS)
        din <= store.exists(int'(addr)) ? store[int'(addr)] : 8'h00;
      else
        din <= 8'hEE;
    end else begin
      wasOn = 0;
      din <= 8'hEE;
    end
  end
endmodule

module sram_async_ctl_tb_top;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 19) / 20;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_C    = mx(cyc(55), cyc(25));
  localparam int PULSE_C = mx(mx(cyc(45), cyc(50)), cyc(20) + cyc(25));
  localparam int WHZ_C   = cyc(20);
  localparam int REC_C   = cyc(55);
  localparam int GAP2_C  = cyc(100);

  logic clk = 0;
  logic rstN = 0;
  always #10 clk = ~clk;

  logic        reqValid = 0, reqWrite = 0, retainReq = 0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspReady, memCeN, memCe2, memOeN, memWeN, memDrv;
  logic [7:0]  rspData, memDout, memDin;
  logic [17:0] memAddr;

  logic        req2Valid = 0;
  logic [17:0] req2Addr = '0;
  logic        rsp2Ready, mem2CeN, mem2Ce2, mem2OeN, mem2WeN, mem2Drv;
  logic [7:0]  rsp2Data, mem2Dout, mem2Din;
  logic [17:0] mem2Addr;

  sram_async_ctl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .retainReq(retainReq),
    .rspReady(rspReady), .rspData(rspData), .memAddr(memAddr), .memCeN(memCeN),
    .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN), .memDout(memDout),
    .memDrv(memDrv), .memDin(memDin)
  );

  sram_mem_model mem_i (
    .clk(clk), .addr(memAddr), .ceN(memCeN), .ce2(memCe2), .oeN(memOeN),
    .weN(memWeN), .drv(memDrv), .dout(memDout), .din(memDin)
  );

  sram_async_ctl #(.T_RC_NS(100), .T_WC_NS(100)) dut2_i (
    .clk(clk), .rstN(rstN), .reqValid(req2Valid), .reqWrite(1'b0),
    .reqAddr(req2Addr), .reqWdata(8'h00), .retainReq(1'b0),
    .rspReady(rsp2Ready), .rspData(rsp2Data), .memAddr(mem2Addr), .memCeN(mem2CeN),
    .memCe2(mem2Ce2), .memOeN(mem2OeN), .memWeN(mem2WeN), .memDout(mem2Dout),
    .memDrv(mem2Drv), .memDin(mem2Din)
  );

  sram_mem_model mem2_i (
    .clk(clk), .addr(mem2Addr), .ceN(mem2CeN), .ce2(mem2Ce2), .oeN(mem2OeN),
    .weN(mem2WeN), .drv(mem2Drv), .dout(mem2Dout), .din(mem2Din)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycNum  = 0;
  bit done    = 0;
  logic [7:0] expMem [int];

  always @(posedge clk) cycNum <= cycNum + 1;

  task automatic expectPins(input bit sel, input bit oeN, input bit weN,
                            input bit drv, input bit rdy, input string tag);
    nChecks++;
    if (memCeN !== !sel || memCe2 !== sel || memOeN !== oeN || memWeN !== weN ||
        memDrv !== drv || rspReady !== rdy) begin
      nFails++;
      $display("FAIL %s: actual ceN=%b ce2=%b oeN=%b weN=%b drv=%b rdy=%b expected ceN=%b ce2=%b oeN=%b weN=%b drv=%b rdy=%b",
               tag, memCeN, memCe2, memOeN, memWeN, memDrv, rspReady,
               !sel, sel, oeN, weN, drv, rdy);
    end
  endtask

  task automatic checkVal(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [17:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : 8'h00;
  endfunction

  // Read with the request raised at a falling edge; ends at the ready sample.
  task automatic runRead(input logic [17:0] a, input string tag);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    expectPins(1, 0, 1, 0, 0, "R2 read select");
    checkVal(32'(memAddr), 32'(a), "R2 read address");
    for (int k = 1; k < RD_C; k++) begin
      @(negedge clk);
      expectPins(1, 0, 1, 0, 0, "R2 read hold");
    end
    @(negedge clk);
    expectPins(0, 1, 1, 0, 1, "R3 read complete");
    checkVal(32'(rspData), 32'(expRead(a)), tag);
    reqValid = 0;
  endtask

  task automatic runWrite(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    expectPins(1, 1, 0, 0, 0, "R4 write start");
    for (int k = 1; k < PULSE_C; k++) begin
      @(negedge clk);
      expectPins(1, 1, 0, (k >= WHZ_C), 0, "R4 R5 write pulse");
      if (k >= WHZ_C) checkVal(32'(memDout), 32'(d), "R5 write data");
    end
    @(negedge clk);
    expectPins(0, 1, 1, 1, 0, "R5 WE rise with drive held");
    @(negedge clk);
    expectPins(0, 1, 1, 0, 1, "R5 drive release and ready");
    reqValid = 0; reqWrite = 0;
    expMem[int'(a)] = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int c1, c2;
    repeat (2) @(negedge clk);
    expectPins(0, 1, 1, 0, 0, "R1 in reset");
    rstN = 1;
    repeat (3) begin
      @(negedge clk);
      expectPins(0, 1, 1, 0, 0, "R1 idle after reset");
    end

    // R6: read of an unwritten location returns the model default
    runRead(18'h00010, "R6 unwritten read");
    runWrite(18'h00000, 8'hA5);
    runWrite(18'h3FFFF, 8'hFF);
    runWrite(18'h12345, 8'h00);
    runWrite(18'h00007, 8'h3C);
    runRead(18'h00000, "R6 read back 0");
    runRead(18'h3FFFF, "R6 read back top");
    runRead(18'h12345, "R6 read back zero byte");
    runWrite(18'h00000, 8'h5A);
    runRead(18'h00000, "R6 overwrite read back");
    @(negedge clk);
    expectPins(0, 1, 1, 0, 0, "R1 idle between accesses");

    // R7: back-to-back reads at defaults start RD_C+1 cycles apart
    reqValid = 1; reqWrite = 0; reqAddr = 18'h00007;
    @(negedge clk);
    c1 = cycNum;
    expectPins(1, 0, 1, 0, 0, "R2 first of pair");
    repeat (RD_C) @(negedge clk);
    expectPins(0, 1, 1, 0, 1, "R3 first of pair ready");
    checkVal(32'(rspData), 32'(expRead(18'h00007)), "R6 first of pair data");
    reqAddr = 18'h3FFFF;
    @(negedge clk);
    c2 = cycNum;
    expectPins(1, 0, 1, 0, 0, "R7 second start follows ready");
    checkVal(32'(c2 - c1), 32'(RD_C + 1), "R7 default start spacing");
    repeat (RD_C) @(negedge clk);
    checkVal(32'(rspData), 32'(expRead(18'h3FFFF)), "R6 second of pair data");
    reqValid = 0;

    // R7: longer cycle times hold off the next start
    @(negedge clk);
    req2Valid = 1; req2Addr = 18'h00001;
    for (int w = 0; w < 10 && mem2CeN; w++) @(negedge clk);
    c1 = cycNum;
    for (int w = 0; w < 10 && !rsp2Ready; w++) @(negedge clk);
    req2Addr = 18'h00002;
    for (int w = 0; w < 10 && !mem2CeN; w++) @(negedge clk);
    for (int w = 0; w < 10 && mem2CeN; w++) @(negedge clk);
    c2 = cycNum;
    checkVal(32'(c2 - c1), 32'(GAP2_C), "R7 minimum cycle spacing");
    for (int w = 0; w < 10 && !rsp2Ready; w++) @(negedge clk);
    req2Valid = 0;

    // R8: retention with a pending request; retention wins
    @(negedge clk);
    retainReq = 1; reqValid = 1; reqWrite = 0; reqAddr = 18'h00000;
    repeat (5) begin
      @(negedge clk);
      expectPins(0, 1, 1, 0, 0, "R8 request blocked in retention");
    end
    // R9: release, then the first select appears on edge REC_C+1
    retainReq = 0;
    for (int j = 0; j <= REC_C; j++) begin
      @(negedge clk);
      expectPins(0, 1, 1, 0, 0, "R9 recovery wait");
    end
    @(negedge clk);
    expectPins(1, 0, 1, 0, 0, "R9 first access after recovery");
    repeat (RD_C - 1) @(negedge clk);
    @(negedge clk);
    expectPins(0, 1, 1, 0, 1, "R3 read after recovery");
    checkVal(32'(rspData), 32'(expRead(18'h00000)), "R6 read after recovery");
    reqValid = 0;
    repeat (2) begin
      @(negedge clk);
      expectPins(0, 1, 1, 0, 0, "R1 idle at end");
    end
    finishRun();
  end

endmodule